// File: doc/BRIEF.md
# Grouped Condition-Flag Rename Table

This block keeps track of which in-flight instruction is the newest producer of each condition-flag group. The five flags used in normal execution (overflow, carry, zero, parity, sign) are folded into three tracked groups. Zero, parity and sign are always written together, so they form one group. Overflow and carry each have their own group. Because each group has its own entry, an instruction that reads only carry does not wait on an older instruction that wrote only overflow. This removes false dependences on the flag register.

At dispatch, each instruction presents a read mask, a write mask and its tag. For every group it reads, the table reports either the tag of the producer it must wait on, or that the group is ready. Ready means no live producer. For every group it writes, the instruction becomes the new producer. When a producer retires, its entry returns to null, but only if no newer writer has replaced it. A flush drops all three entries. Flag values travel with the producer's physical register and are not held here.

Top module: `flag_rename_table`

## Requirements
- R1: After reset all three entries are null, so every group read at dispatch is reported ready: pending low and tag zero.
- R2: Mask bit 0 selects the overflow group, bit 1 the carry group and bit 2 the zero/parity/sign group. A dispatch with a write bit set makes its tag the producer of that group from the next cycle on.
- R3: For each group with its read bit set while dispatch is valid, `depPending` is high and `depTag` (group g in bits g*7 +: 7) holds the recorded producer tag when the entry is live. Otherwise the pending bit is low and the tag field is zero.
- R4: Writing one group leaves the other two entries unchanged.
- R5: When one dispatch both reads and writes a group, the read reports the producer held before the write, or ready if there was none.
- R6: A retire whose tag equals a live entry's tag makes that entry null from the next cycle on.
- R7: A retire whose tag matches no entry leaves all entries unchanged.
- R8: If a retire matches an entry in the same cycle that a dispatch writes that group, the new producer is kept.
- R9: Flush nulls all three entries from the next cycle on, and takes priority over a dispatch write in the same cycle.
- R10: A dispatch with no write bits set, or any write mask while dispatch is not valid, leaves the table unchanged.
- R11: A lookup reflects the table as it stood at the start of the cycle, so a retire of the producer in the same cycle does not change what the lookup reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush: null all entries |
| dispValid | input | 1 | Dispatch slot holds an instruction |
| dispRdMask | input | 3 | Flag groups read (bit0 OF, bit1 CF, bit2 ZPS) |
| dispWrMask | input | 3 | Flag groups written, same bit order |
| dispTag | input | 7 | Tag of the dispatching instruction |
| retValid | input | 1 | An instruction retires this cycle |
| retTag | input | 7 | Tag of the retiring instruction |
| depPending | output | 3 | Per group: read group has a live producer |
| depTag | output | 21 | Per group producer tag, group g at bits g*7 +: 7 |

## Verification
The bench targets overlaps in the same cycle. A read and a write to one group must return the old producer; a table that forwards the new tag would make an instruction wait on itself. A retire that arrives with a newer write must keep the newer producer; getting this wrong releases a later consumer too early. A retire whose tag no longer matches must be ignored; a table that cleared anyway would lose a live dependence. Flush must win over a dispatch write, and an instruction with no flag writes must leave every group unchanged. Random traffic biased toward matching retire tags covers these cases together.

// File: rtl/flag_rename_pkg.sv
package flag_rename_pkg;
  parameter int NUM_GROUPS = 3;
  parameter int TAG_W      = 7;

  localparam int GRP_OF  = 0;
  localparam int GRP_CF  = 1;
  localparam int GRP_ZPS = 2;

  typedef struct packed {
    logic [NUM_GROUPS-1:0] wrEn;
    logic [NUM_GROUPS-1:0] clrEn;
  } flagStrobes_t;
endpackage

// File: rtl/flag_rename_ctrl.sv
module flag_rename_ctrl
  import flag_rename_pkg::*;
#(
  parameter int TagW = TAG_W,
  localparam int TagBusW = NUM_GROUPS * TagW
) (
  input  logic                   flush,
  input  logic                   dispValid,
  input  logic [NUM_GROUPS-1:0]  dispWrMask,
  input  logic                   retValid,
  input  logic [TagW-1:0]        retTag,
  input  logic [NUM_GROUPS-1:0]  entryValid,
  input  logic [TagBusW-1:0]     entryTag,
  output flagStrobes_t           strobes
);
  logic [NUM_GROUPS-1:0] retHit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    assign retHit[g] = retValid && entryValid[g] && (entryTag[g*TagW +: TagW] == retTag);
  end

  always_comb begin
    strobes = '0;
    if (flush) begin
      strobes.clrEn = '1;
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        strobes.wrEn[g]  = dispValid && dispWrMask[g];
        strobes.clrEn[g] = retHit[g] && !(dispValid && dispWrMask[g]);
      end
    end
  end
endmodule

// File: rtl/flag_rename_datapath.sv
module flag_rename_datapath
  import flag_rename_pkg::*;
#(
  parameter int TagW = TAG_W,
  localparam int TagBusW = NUM_GROUPS * TagW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  flagStrobes_t          strobes,
  input  logic                  dispValid,
  input  logic [NUM_GROUPS-1:0] dispRdMask,
  input  logic [TagW-1:0]       dispTag,
  output logic [NUM_GROUPS-1:0] entryValid,
  output logic [TagBusW-1:0]    entryTag,
  output logic [NUM_GROUPS-1:0] depPending,
  output logic [TagBusW-1:0]    depTag
);
  logic [NUM_GROUPS-1:0] validQ;
  logic [TagW-1:0]       tagQ [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        tagQ[g]   <= '0;
      end else if (strobes.clrEn[g]) begin
        validQ[g] <= 1'b0;
      end else if (strobes.wrEn[g]) begin
        validQ[g] <= 1'b1;
        tagQ[g]   <= dispTag;
      end
    end

    assign entryValid[g]               = validQ[g];
    assign entryTag[g*TagW +: TagW]    = tagQ[g];
    assign depPending[g]               = dispValid && dispRdMask[g] && validQ[g];
    assign depTag[g*TagW +: TagW]      = depPending[g] ? tagQ[g] : '0;

    // R2: a write strobe installs the dispatch tag as live producer
    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrEn[g] && !strobes.clrEn[g] |=> validQ[g] && (tagQ[g] == $past(dispTag)));

    // R6 / R9: a clear strobe leaves the entry null
    p_clear_nulls_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clrEn[g] |=> !validQ[g]);

    // R10: no strobe, no change
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrEn[g] && !strobes.clrEn[g] |=> $stable(validQ[g]) && $stable(tagQ[g]));
  end
endmodule

// File: rtl/flag_rename_table.sv
module flag_rename_table
  import flag_rename_pkg::*;
#(
  parameter int TagW = TAG_W,
  localparam int TagBusW = NUM_GROUPS * TagW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  dispValid,
  input  logic [NUM_GROUPS-1:0] dispRdMask,
  input  logic [NUM_GROUPS-1:0] dispWrMask,
  input  logic [TagW-1:0]       dispTag,
  input  logic                  retValid,
  input  logic [TagW-1:0]       retTag,
  output logic [NUM_GROUPS-1:0] depPending,
  output logic [TagBusW-1:0]    depTag
);
  flagStrobes_t          strobes;
  logic [NUM_GROUPS-1:0] entryValid;
  logic [TagBusW-1:0]    entryTag;

  flag_rename_ctrl #(.TagW(TagW)) uCtrl (
    .flush      (flush),
    .dispValid  (dispValid),
    .dispWrMask (dispWrMask),
    .retValid   (retValid),
    .retTag     (retTag),
    .entryValid (entryValid),
    .entryTag   (entryTag),
    .strobes    (strobes)
  );

  flag_rename_datapath #(.TagW(TagW)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dispValid  (dispValid),
    .dispRdMask (dispRdMask),
    .dispTag    (dispTag),
    .entryValid (entryValid),
    .entryTag   (entryTag),
    .depPending (depPending),
    .depTag     (depTag)
  );

  // R9: after a flush no group reports a live producer
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (depPending == '0));

  // R3: with no dispatch nothing is reported pending
  p_idle_no_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dispValid |-> (depPending == '0) && (depTag == '0));
endmodule

// File: tb/flag_rename_table_test.sv
`timescale 1ns/1ps
module flag_rename_table_test;
  localparam int NG = 3;
  localparam int TW = 7;

  logic clk = 1'b0;
  logic rstN;
  logic flush, dispValid, retValid;
  logic [NG-1:0] dispRdMask, dispWrMask;
  logic [TW-1:0] dispTag, retTag;
  logic [NG-1:0] depPending;
  logic [NG*TW-1:0] depTag;

  int checks = 0;
  int failures = 0;
  bit mValid [NG];
  logic [TW-1:0] mTag [NG];

  always #2.5 clk = ~clk;

  flag_rename_table uut (
    .clk(clk), .rstN(rstN), .flush(flush), .dispValid(dispValid),
    .dispRdMask(dispRdMask), .dispWrMask(dispWrMask), .dispTag(dispTag),
    .retValid(retValid), .retTag(retTag), .depPending(depPending), .depTag(depTag)
  );

  function automatic logic [NG-1:0] expPending(input logic v, input logic [NG-1:0] rd);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = v && rd[g] && mValid[g];
    return r;
  endfunction

  function automatic logic [NG*TW-1:0] expTag(input logic v, input logic [NG-1:0] rd);
    logic [NG*TW-1:0] r;
    r = '0;
    for (int g = 0; g < NG; g++)
      if (v && rd[g] && mValid[g]) r[g*TW +: TW] = mTag[g];
    return r;
  endfunction

  task automatic step(input logic v, input logic [NG-1:0] rd, input logic [NG-1:0] wr,
                      input logic [TW-1:0] tg, input logic rv, input logic [TW-1:0] rt,
                      input logic fl, input string req);
    logic [NG-1:0] ep;
    logic [NG*TW-1:0] et;
    @(negedge clk);
    dispValid = v; dispRdMask = rd; dispWrMask = wr; dispTag = tg;
    retValid = rv; retTag = rt; flush = fl;
    #1;
    ep = expPending(v, rd);
    et = expTag(v, rd);
    checks++;
    if (depPending !== ep || depTag !== et) begin
      failures++;
      $display("FAIL %s: pending=%b tag=%h expected pending=%b tag=%h",
               req, depPending, depTag, ep, et);
    end
    @(posedge clk);
    if (fl) begin
      for (int g = 0; g < NG; g++) mValid[g] = 1'b0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (v && wr[g]) begin
          mValid[g] = 1'b1; mTag[g] = tg;
        end else if (rv && mValid[g] && mTag[g] == rt) begin
          mValid[g] = 1'b0;
        end
      end
    end
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; flush = 0; dispValid = 0; retValid = 0;
    dispRdMask = 0; dispWrMask = 0; dispTag = 0; retTag = 0;
    for (int g = 0; g < NG; g++) begin mValid[g] = 0; mTag[g] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    step(1, 3'b111, 3'b000, 7'd0, 0, 7'd0, 0, "R1 reset null");
    step(1, 3'b000, 3'b001, 7'd5, 0, 7'd0, 0, "R2 write OF");
    step(1, 3'b001, 3'b010, 7'd9, 0, 7'd0, 0, "R2 read OF");
    step(1, 3'b111, 3'b000, 7'd0, 0, 7'd0, 0, "R4 independent groups");
    step(1, 3'b100, 3'b100, 7'd12, 0, 7'd0, 0, "R5 read+write ZPS empty");
    step(1, 3'b100, 3'b100, 7'd13, 0, 7'd0, 0, "R5 read+write ZPS older");
    step(1, 3'b111, 3'b000, 7'd0, 1, 7'd99, 0, "R7 retire mismatch same cycle");
    step(1, 3'b111, 3'b000, 7'd0, 1, 7'd12, 0, "R7 retire stale tag");
    step(1, 3'b111, 3'b000, 7'd0, 0, 7'd0, 0, "R7 entries kept");
    step(1, 3'b001, 3'b000, 7'd0, 1, 7'd5, 0, "R11 lookup before retire");
    step(1, 3'b001, 3'b000, 7'd0, 0, 7'd0, 0, "R6 retired OF is ready");
    step(1, 3'b000, 3'b010, 7'd20, 1, 7'd9, 0, "R8 retire+write CF");
    step(1, 3'b010, 3'b000, 7'd0, 0, 7'd0, 0, "R8 new CF producer kept");
    step(0, 3'b111, 3'b111, 7'd33, 0, 7'd0, 0, "R10 invalid dispatch");
    step(1, 3'b111, 3'b000, 7'd34, 0, 7'd0, 0, "R10 after invalid write");
    step(1, 3'b111, 3'b000, 7'd0, 0, 7'd0, 0, "R10 no-flag instruction");
    step(1, 3'b111, 3'b111, 7'd40, 0, 7'd0, 1, "R9 flush with write");
    step(1, 3'b111, 3'b000, 7'd0, 0, 7'd0, 0, "R9 all null after flush");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic v, rv, fl;
      logic [NG-1:0] rd, wr;
      logic [TW-1:0] tg, rt;
      int pick;
      v  = ($urandom % 8) != 0;
      rd = $urandom;
      wr = (($urandom % 3) == 0) ? 3'b000 : 3'($urandom);
      tg = $urandom;
      rv = ($urandom % 2) != 0;
      pick = $urandom % NG;
      rt = (($urandom % 4) != 0) ? mTag[pick] : 7'($urandom);
      fl = ($urandom % 64) == 0;
      step(v, rd, wr, tg, rv, rt, fl, "R3 random lookup");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule